// File: doc/BRIEF.md
# Speed-Loop PI Duty Generator

This block closes a sampled speed loop for a motor whose DC-link voltage comes from a buck-boost stage. On each sample strobe it subtracts the measured speed from the reference speed, both signed integer rpm values. It scales that difference into an equivalent voltage error using a fixed-point ratio of maximum link voltage to maximum speed. It then applies an incremental (velocity-form) PI step and clamps the result. The clamped command drives a comparator against a free-running triangular carrier, which yields the single gate signal for the converter switch.

A small sequencer orders the arithmetic. It has three states. `ST_IDLE` waits for `sample_stb` and captures both speeds (transition IDLE→SCALE). `ST_SCALE` registers the voltage error (transition SCALE→UPDATE, unconditional). `ST_UPDATE` commits the new command and the previous-error memory (transition UPDATE→IDLE, unconditional). The carrier runs independently of the sequencer. It picks up a new command only at its valley, so a pulse is never reshaped partway through a period. The defaults set a carrier half-period of 3125 clocks, which gives 20 kHz at 125 MHz. They also set gains of 0.6 (proportional) and 5 × 50 µs (integral × sample interval), and a scaling of 480 V / 3000 rpm. All gains use 16 fractional bits.

Top module: `speed_pi_pwm`

## Requirements
- R1: The voltage error is Ve = rnd((ref_rpm − meas_rpm) × VSCALE), where rnd(p) = (p + 2^(FRAC−1)) >>> FRAC. This is round-to-nearest with ties going toward positive infinity, and it holds for negative errors too.
- R2: Each accepted sample sets U(k) = clamp(U(k−1) + rnd(KP × (Ve(k) − Ve(k−1))) + rnd(KI_DT × Ve(k))), with KP, KI_DT and VSCALE given as integers carrying FRAC fractional bits.
- R3: `duty_cmd` never leaves [U_MIN, U_MAX]. The stored command itself is clamped, so a reversed error moves the command away from a limit on the very next sample (no wind-up).
- R4: `sample_stb` is acted on only in ST_IDLE. `duty_cmd` takes its new value after the third rising edge, counting the edge at which the strobe is seen high, and holds at every other edge.
- R5: A strobe, or a change on `ref_rpm`/`meas_rpm`, during ST_SCALE or ST_UPDATE has no effect. The result equals that of the single captured sample.
- R6: The carrier counts 0,1,…,CAR_PEAK,…,1 and repeats, so one period is 2×CAR_PEAK clocks. `gate` is high while the latched command is greater than the carrier value. For a steady command L with 1 ≤ L ≤ CAR_PEAK, gate is high for one contiguous run of 2L−1 clocks per period. For L ≤ 0 it is never high.
- R7: The command is latched only at the clock where the carrier is 0. If the command changes from L1 to L2 during the rising half of the carrier, the next high run lasts L1 + L2 − 1 clocks.
- R8: A synchronous `rst` returns the sequencer to ST_IDLE and clears U(k−1), Ve(k−1), the carrier and the latched command. `duty_cmd` then reads 0 and `gate` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | One-clock sample request |
| ref_rpm | input | W_SPD | Reference speed, signed rpm |
| meas_rpm | input | W_SPD | Measured speed, signed rpm |
| duty_cmd | output | W_U | Clamped PI command, signed |
| gate | output | 1 | PWM gate for the converter switch |

## Verification
A new command is due exactly three rising edges after the strobe is sampled. The bench drives the strobe on a falling edge and checks `duty_cmd` two falling edges later, when the old value must still be present. It checks again one falling edge after that, when the new value must appear, so an early or late update is caught. Gate timing is measured in whole clocks as high-run lengths and rise-to-rise spacing, sampled on falling edges. After a command change, the bench waits at least two carrier periods before it trusts a run length. The exception is the deliberate mid-period change: there, the run that straddles the next valley must mix the old and new command, as R7 requires.

// File: rtl/speed_pi_pkg.sv
package speed_pi_pkg;

    localparam int PW = 48;

    typedef logic signed [PW-1:0] prod_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCALE  = 2'd1,
        ST_UPDATE = 2'd2
    } loop_state_e;

    // Round to nearest (ties toward +inf), dropping frac fractional bits.
    function automatic prod_t round_q(input prod_t p, input int frac);
        prod_t half;
        half = prod_t'(1) <<< (frac - 1);
        return (p + half) >>> frac;
    endfunction

endpackage

// File: rtl/spd_err_scale.sv
module spd_err_scale
    import speed_pi_pkg::*;
#(
    parameter int W_SPD  = 16,
    parameter int VSCALE = 10486,
    parameter int FRAC   = 16
) (
    input  logic signed [W_SPD-1:0] ref_rpm,
    input  logic signed [W_SPD-1:0] meas_rpm,
    output prod_t                   v_err
);

    logic signed [W_SPD:0] spd_diff;
    prod_t                 scaled;

    always_comb begin
        spd_diff = $signed({ref_rpm[W_SPD-1], ref_rpm})
                 - $signed({meas_rpm[W_SPD-1], meas_rpm});
        scaled   = prod_t'(spd_diff) * prod_t'(VSCALE);
        v_err    = round_q(scaled, FRAC);
    end

endmodule

// File: rtl/pi_incr.sv
module pi_incr
    import speed_pi_pkg::*;
#(
    parameter int KP    = 39322,
    parameter int KI_DT = 16,
    parameter int FRAC  = 16,
    parameter int U_MIN = 0,
    parameter int U_MAX = 3125,
    parameter int W_U   = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd,
    input  prod_t                 v_err,
    output logic signed [W_U-1:0] u_cmd
);

    prod_t ve_prev;
    prod_t p_term;
    prod_t i_term;
    prod_t u_sum;
    prod_t u_next;

    always_comb begin
        p_term = round_q((v_err - ve_prev) * prod_t'(KP), FRAC);
        i_term = round_q(v_err * prod_t'(KI_DT), FRAC);
        u_sum  = prod_t'(u_cmd) + p_term + i_term;
        if (u_sum > prod_t'(U_MAX))
            u_next = prod_t'(U_MAX);
        else if (u_sum < prod_t'(U_MIN))
            u_next = prod_t'(U_MIN);
        else
            u_next = u_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ve_prev <= '0;
            u_cmd   <= '0;
        end else if (upd) begin
            ve_prev <= v_err;
            u_cmd   <= W_U'(u_next);
        end
    end

    assert_cmd_range_R3: assert property (@(posedge clk) disable iff (rst)
        (u_cmd >= U_MIN) && (u_cmd <= U_MAX));

    assert_hold_between_R4: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(u_cmd));

    assert_clear_state_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (u_cmd == '0) && (ve_prev == '0));

endmodule

// File: rtl/tri_pwm.sv
module tri_pwm #(
    parameter int CAR_PEAK = 3125,
    parameter int W_U      = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [W_U-1:0] cmd,
    output logic                  gate
);

    localparam int CW = $clog2(CAR_PEAK + 1);

    logic [CW-1:0]         car;
    logic                  falling;
    logic signed [W_U-1:0] held;
    logic signed [31:0]    held_i;
    logic signed [31:0]    car_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            car     <= '0;
            falling <= 1'b0;
            held    <= '0;
        end else begin
            if (!falling) begin
                car <= car + CW'(1);
                if (car == CW'(CAR_PEAK - 1)) falling <= 1'b1;
            end else begin
                car <= car - CW'(1);
                if (car == CW'(1)) falling <= 1'b0;
            end
            if (car == '0) held <= cmd;
        end
    end

    always_comb begin
        held_i = 32'(held);
        car_i  = 32'(car);
        gate   = held_i > car_i;
    end

    assert_valley_latch_R7: assert property (@(posedge clk) disable iff (rst)
        (car != '0) |=> $stable(held));

    assert_carrier_range_R6: assert property (@(posedge clk) disable iff (rst)
        car <= CW'(CAR_PEAK));

    assert_gate_low_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !gate);

endmodule

// File: rtl/speed_pi_pwm.sv
module speed_pi_pwm
    import speed_pi_pkg::*;
#(
    parameter int W_SPD    = 16,
    parameter int W_U      = 16,
    parameter int FRAC     = 16,
    parameter int KP       = 39322,
    parameter int KI_DT    = 16,
    parameter int VSCALE   = 10486,
    parameter int U_MIN    = 0,
    parameter int U_MAX    = 3125,
    parameter int CAR_PEAK = 3125
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_stb,
    input  logic signed [W_SPD-1:0] ref_rpm,
    input  logic signed [W_SPD-1:0] meas_rpm,
    output logic signed [W_U-1:0]   duty_cmd,
    output logic                    gate
);

    loop_state_e state;
    loop_state_e nxt;

    logic cap_en;
    logic scale_en;
    logic upd_en;

    logic signed [W_SPD-1:0] ref_q;
    logic signed [W_SPD-1:0] meas_q;
    prod_t                   ve_c;
    prod_t                   ve_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (sample_stb) nxt = ST_SCALE;
            ST_SCALE:  nxt = ST_UPDATE;
            ST_UPDATE: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        cap_en   = 1'b0;
        scale_en = 1'b0;
        upd_en   = 1'b0;
        unique case (state)
            ST_IDLE:   cap_en   = sample_stb;
            ST_SCALE:  scale_en = 1'b1;
            ST_UPDATE: upd_en   = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            meas_q <= '0;
            ve_q   <= '0;
        end else begin
            if (cap_en) begin
                ref_q  <= ref_rpm;
                meas_q <= meas_rpm;
            end
            if (scale_en) ve_q <= ve_c;
        end
    end

    spd_err_scale #(
        .W_SPD (W_SPD),
        .VSCALE(VSCALE),
        .FRAC  (FRAC)
    ) u_scale (
        .ref_rpm (ref_q),
        .meas_rpm(meas_q),
        .v_err   (ve_c)
    );

    pi_incr #(
        .KP   (KP),
        .KI_DT(KI_DT),
        .FRAC (FRAC),
        .U_MIN(U_MIN),
        .U_MAX(U_MAX),
        .W_U  (W_U)
    ) u_pi (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd_en),
        .v_err(ve_q),
        .u_cmd(duty_cmd)
    );

    tri_pwm #(
        .CAR_PEAK(CAR_PEAK),
        .W_U     (W_U)
    ) u_pwm (
        .clk (clk),
        .rst (rst),
        .cmd (duty_cmd),
        .gate(gate)
    );

    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && sample_stb) |=> (state == ST_SCALE));

    assert_sequence_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCALE) |=> (state == ST_UPDATE));

    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(ref_q) && $stable(meas_q));

endmodule

// File: tb/test_speed_pi_pwm.sv
`timescale 1ns/1ps
module test_speed_pi_pwm;

    localparam int CAR_PEAK = 32;
    localparam int U_MIN    = 0;
    localparam int U_MAX    = 30;
    localparam int KP       = 39322;
    localparam int KI_DT    = 16384;
    localparam int VSCALE   = 10486;
    localparam int FRAC     = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_stb = 1'b0;
    logic signed [15:0] ref_rpm = '0;
    logic signed [15:0] meas_rpm = '0;
    logic signed [15:0] duty_cmd;
    logic               gate;

    int n_chk = 0;
    int n_bad = 0;
    longint um  = 0;
    longint vep = 0;

    always #4 clk = ~clk;

    speed_pi_pwm #(
        .W_SPD(16), .W_U(16), .FRAC(FRAC), .KP(KP), .KI_DT(KI_DT),
        .VSCALE(VSCALE), .U_MIN(U_MIN), .U_MAX(U_MAX), .CAR_PEAK(CAR_PEAK)
    ) i_speed_pi_pwm (
        .clk(clk), .rst(rst), .sample_stb(sample_stb),
        .ref_rpm(ref_rpm), .meas_rpm(meas_rpm),
        .duty_cmd(duty_cmd), .gate(gate)
    );

    function automatic longint rnd(input longint p);
        return (p + 64'sd32768) >>> FRAC;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_next(input int r, input int m, output longint ve);
        longint s;
        ve = rnd(longint'(r - m) * VSCALE);
        s  = um + rnd(KP * (ve - vep)) + rnd(KI_DT * ve);
        if (s > U_MAX) s = U_MAX;
        if (s < U_MIN) s = U_MIN;
        return s;
    endfunction

    task automatic do_sample(input int r, input int m, input string req);
        longint ve, s, old;
        s = model_next(r, m, ve);
        old = um;
        @(negedge clk); ref_rpm = 16'(r); meas_rpm = 16'(m); sample_stb = 1'b1;
        @(negedge clk); sample_stb = 1'b0;
        @(negedge clk); chk({req, " (R4 not yet due)"}, duty_cmd, old);
        @(negedge clk); chk(req, duty_cmd, s);
        vep = ve; um = s;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic meas_run(output int len, output int per);
        logic prev;
        prev = gate;
        while (1) begin
            @(negedge clk);
            if (!prev && gate) break;
            prev = gate;
        end
        len = 0; per = 0;
        while (gate) begin len++; per++; @(negedge clk); end
        while (!gate) begin per++; @(negedge clk); end
    endtask

    task automatic wait_fall();
        logic prev;
        prev = gate;
        while (1) begin
            @(negedge clk);
            if (prev && !gate) break;
            prev = gate;
        end
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        wait_cycles(2);
        rst = 1'b0;
        um = 0; vep = 0;
    endtask

    // R8: reset state
    task automatic t_reset();
        int highs;
        wait_cycles(3);
        chk("R8 duty in reset", duty_cmd, 0);
        chk("R8 gate in reset", gate, 0);
        rst = 1'b0;
        um = 0; vep = 0;
        highs = 0;
        for (int i = 0; i < 2 * CAR_PEAK + 4; i++) begin
            @(negedge clk);
            if (gate) highs++;
        end
        chk("R8 gate low after reset", highs, 0);
        chk("R8 duty after reset", duty_cmd, 0);
    endtask

    // R1, R2: step response and mixed-sign errors
    task automatic t_step();
        do_sample(1000, 900, "R2 first step");
        chk("R1 R2 first step value", duty_cmd, 14);
        do_sample(1000, 900, "R2 integral only");
        do_sample(1000, 1000, "R2 proportional drop");
        do_sample(1000, 1003, "R1 negative rounding");
        do_sample(1000, 990, "R1 small positive");
    endtask

    // R6, R7: pulse widths and valley latching
    task automatic t_pwm();
        int len, per;
        longint l1, l2;
        apply_reset();
        do_sample(1000, 900, "R2 set pwm level");
        l1 = um;
        wait_cycles(4 * CAR_PEAK + 4);
        meas_run(len, per);
        chk("R6 run length", len, 2 * l1 - 1);
        chk("R6 period", per, 2 * CAR_PEAK);
        wait_fall();
        do_sample(1000, 1000, "R2 mid-period change");
        l2 = um;
        meas_run(len, per);
        chk("R7 straddling run", len, l1 + l2 - 1);
        meas_run(len, per);
        chk("R7 run after latch", len, 2 * l2 - 1);
    endtask

    // R3: clamping and no wind-up
    task automatic t_clamp();
        int highs;
        for (int i = 0; i < 3; i++) do_sample(3000, 0, "R3 drive high");
        chk("R3 upper limit", duty_cmd, U_MAX);
        for (int i = 0; i < 4; i++) do_sample(0, 3000, "R3 drive low");
        chk("R3 lower limit", duty_cmd, U_MIN);
        wait_cycles(4 * CAR_PEAK + 4);
        highs = 0;
        for (int i = 0; i < 2 * CAR_PEAK; i++) begin
            @(negedge clk);
            if (gate) highs++;
        end
        chk("R6 zero duty", highs, 0);
        do_sample(1000, 990, "R3 immediate recovery");
    endtask

    // R5: strobes and input changes while busy are ignored
    task automatic t_busy();
        longint ve, s;
        s = model_next(1000, 950, ve);
        @(negedge clk); ref_rpm = 16'sd1000; meas_rpm = 16'sd950; sample_stb = 1'b1;
        @(negedge clk); ref_rpm = 16'sd3000; meas_rpm = 16'sd0;
        @(negedge clk); ref_rpm = -16'sd3000;
        @(negedge clk); sample_stb = 1'b0;
        chk("R5 busy strobe result", duty_cmd, s);
        vep = ve; um = s;
        wait_cycles(6);
        chk("R5 no second update", duty_cmd, s);
    endtask

    // R8: reset mid-run clears previous error
    task automatic t_reset_mid();
        do_sample(1000, 800, "R2 before reset");
        apply_reset();
        @(negedge clk);
        chk("R8 duty cleared", duty_cmd, 0);
        chk("R8 gate cleared", gate, 0);
        do_sample(1000, 900, "R8 previous error cleared");
        chk("R8 fresh step value", duty_cmd, 14);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_step();
        t_pwm();
        t_clamp();
        t_busy();
        t_reset_mid();
        summary();
        $finish;
    end

endmodule